// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

A single counter channel for measuring and generating timing. It counts edges from one primary source: one of four input pins, one of four sibling-channel output flags, or the bus clock divided by a power of two between 1 and 128. A secondary source is picked from the four input pins. The secondary source can gate the count, set its direction, act as the second phase of a quadrature pair, or start a counting run. A rising or falling edge on it also copies the counter into a capture register. Measuring a fan tachometer period is a typical use: count the prescaled clock, capture on each tach rising edge, and subtract two consecutive captures.

The counter compares against two compare registers. It uses the first one when it counts up and the second one when it counts down. It reloads from a load register either at the compare value or at rollover. It can stop after the first compare. It drives an output flag in one of eight ways. A sticky compare flag raises an interrupt line when that interrupt is enabled.

Register port (`cfg_addr`): 0 compare A, 1 compare B, 2 capture (read only), 3 load, 4 counter, 5 mode, 6 status. Writes take effect at the clock edge. Reads are combinational.

Top module: `mmtc_channel`

## Requirements
- R1: After synchronous reset the counter, mode, status, capture, output flag and interrupt all read 0.
- R2: Mode bits [11:8] select the primary source. Codes 0-3 select input pin 0-3. Codes 4-7 select sibling flag 0-3. Codes 8-15 select the bus clock divided by 1, 2, 4, 8, 16, 32, 64 or 128, where each divided tick is one count. For pin and sibling sources one count is one rising edge.
- R3: Mode bits [14:12] hold the count mode. Code 1 counts primary rising edges. Code 2 counts both primary edges. Codes 0 and 7 never change the counter.
- R4: Count mode 3 counts primary rising edges only while the secondary source (mode bits [7:6] pick pin 0-3) is high.
- R5: Count mode 4 decodes the primary (phase A) and the secondary (phase B) as quadrature. Each transition steps the counter by one: up when A leads and down when B leads.
- R6: Count mode 5 counts primary rising edges. It counts down while the secondary is high and up while it is low.
- R7: In count mode 6 the counter holds until a secondary rising edge. It then counts primary rising edges until it reaches compare, and holds again.
- R8: With mode bit 4 clear, an up step from 0xFFFF or a down step from 0 loads the load register. With bit 4 set, a step that would reach the compare value loads the load register instead.
- R9: Mode bit 3 set makes modes 1-3 count down, and down counting compares against compare B. Mode bit 5 set clears the enable bit when a compare occurs.
- R10: The capture register takes the counter value on a secondary rising edge when mode bit 15 is 0, and on a falling edge when it is 1. The other edge leaves the capture register unchanged.
- R11: Mode bits [2:0] set the output flag: 0 high while counting, 1 cleared on compare, 2 set on compare, 3 toggled on compare, 4 toggled on compare with the up target alternating A, B, A, and so on, 5 set on compare and cleared on a secondary rising edge, 6 set on compare and cleared on rollover, 7 the primary level while counting.
- R12: A compare sets status bit 0. Writing 1 to that bit clears it and writing 0 leaves it set. The interrupt equals bit 0 AND status bit 1.
- R13: Status bit 2 enables counting. While it is clear the counter holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | External input pins |
| sib_flag | input | 4 | Output flags of sibling channels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| out_flag | output | 1 | Channel output flag |
| cmp_irq | output | 1 | Compare interrupt |

## Verification
The assertions check on every cycle that the counter holds while disabled, that the compare flag rises only after a compare event, that a one-shot compare clears the enable bit, that a compare with reload-at-compare puts the load value in the counter, that the capture register moves only on its selected edge, and that set-on-compare raises the output flag. Only the bench scenarios can show the full counting behaviour: exact counts for each source and divider, quadrature sequences in both directions, the triggered run stopping at compare, the alternating compare targets, and how the output modes evolve over several compares.

// File: rtl/mmtc_pkg.sv
package mmtc_pkg;

    typedef enum logic [2:0] {
        CM_IDLE, CM_RISE, CM_BOTH, CM_GATED, CM_QUAD, CM_SECDIR, CM_TRIG, CM_CASC
    } cmode_e;

    typedef enum logic [2:0] {
        OM_ACTIVE, OM_CLR, OM_SET, OM_TOG, OM_ALT, OM_SETSEC, OM_SETROLL, OM_GATECLK
    } omode_e;

    typedef struct packed {
        logic       cap_fall;
        cmode_e     cmode;
        logic [3:0] pri_sel;
        logic [1:0] sec_sel;
        logic       once;
        logic       len;
        logic       dir;
        omode_e     omode;
    } mode_t;

    localparam logic [2:0] A_CMPA  = 3'd0;
    localparam logic [2:0] A_CMPB  = 3'd1;
    localparam logic [2:0] A_CAPT  = 3'd2;
    localparam logic [2:0] A_LOAD  = 3'd3;
    localparam logic [2:0] A_COUNT = 3'd4;
    localparam logic [2:0] A_MODE  = 3'd5;
    localparam logic [2:0] A_STAT  = 3'd6;

    // returns {up, down} for one quadrature transition
    function automatic logic [1:0] quad_step(input logic pr, input logic pf,
                                             input logic sr, input logic sf,
                                             input logic pl, input logic sl);
        logic up, dn;
        up = (pr & ~sl) | (pf & sl) | (sr & pl) | (sf & ~pl);
        dn = (pr & sl) | (pf & ~sl) | (sr & ~pl) | (sf & pl);
        return {up, dn};
    endfunction

endpackage

// File: rtl/mmtc_prescaler.sv
module mmtc_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PRE_W:0]   ticks
);
    logic [PRE_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    assign ticks[0] = 1'b1;
    for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
        assign ticks[k] = &div_cnt[k-1:0];
    end
endmodule

// File: rtl/mmtc_srcsel.sv
module mmtc_srcsel #(
    parameter int NTAP = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      pin_in,
    input  logic [3:0]      sib_flag,
    input  logic [NTAP-1:0] ticks,
    input  logic [3:0]      pri_sel,
    input  logic [1:0]      sec_sel,
    output logic            p_lvl,
    output logic            p_rise,
    output logic            p_fall,
    output logic            s_lvl,
    output logic            s_rise,
    output logic            s_fall
);
    logic p_q, s_q, is_clk;

    always_comb begin
        is_clk = pri_sel[3];
        if (pri_sel[3])      p_lvl = ticks[pri_sel[2:0]];
        else if (pri_sel[2]) p_lvl = sib_flag[pri_sel[1:0]];
        else                 p_lvl = pin_in[pri_sel[1:0]];
        s_lvl = pin_in[sec_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= 1'b0;
            s_q <= 1'b0;
        end else begin
            p_q <= p_lvl;
            s_q <= s_lvl;
        end
    end

    assign p_rise = is_clk ? p_lvl : (p_lvl & ~p_q);
    assign p_fall = is_clk ? 1'b0  : (~p_lvl & p_q);
    assign s_rise = s_lvl & ~s_q;
    assign s_fall = ~s_lvl & s_q;
endmodule

// File: rtl/mmtc_outflag.sv
module mmtc_outflag
    import mmtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  omode_e omode,
    input  logic   active,
    input  logic   p_lvl,
    input  logic   cmp_evt,
    input  logic   roll_evt,
    input  logic   s_rise,
    output logic   out_flag
);
    logic oflag;

    always_ff @(posedge clk) begin
        if (rst) oflag <= 1'b0;
        else begin
            case (omode)
                OM_CLR:     if (cmp_evt) oflag <= 1'b0;
                OM_SET:     if (cmp_evt) oflag <= 1'b1;
                OM_TOG,
                OM_ALT:     if (cmp_evt) oflag <= ~oflag;
                OM_SETSEC:  if (cmp_evt) oflag <= 1'b1;
                            else if (s_rise) oflag <= 1'b0;
                OM_SETROLL: if (cmp_evt) oflag <= 1'b1;
                            else if (roll_evt) oflag <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (omode)
            OM_ACTIVE:  out_flag = active;
            OM_GATECLK: out_flag = active & p_lvl;
            default:    out_flag = oflag;
        endcase
    end

    // R11
    set_on_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (omode == OM_SET && cmp_evt) |=> oflag);
endmodule

// File: rtl/mmtc_channel.sv
module mmtc_channel
    import mmtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       pin_in,
    input  logic [3:0]       sib_flag,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] cfg_rdata,
    output logic             out_flag,
    output logic             cmp_irq
);
    localparam int NTAP = PRE_W + 1;

    logic [CNT_W-1:0] cmpa_r, cmpb_r, capt_r, load_r, cnt;
    mode_t            mode_r;
    logic             run_en, ie_r, cmp_flag, trig_run, alt;

    logic [NTAP-1:0]  ticks;
    logic p_lvl, p_rise, p_fall, s_lvl, s_rise, s_fall;
    logic up_s, dn_s, step, roll, hit, cmp_evt, roll_evt, cap_evt, active;
    logic [CNT_W-1:0] stepped, target, nxt;

    wire cnt_wr  = cfg_we && cfg_addr == A_COUNT;
    wire stat_wr = cfg_we && cfg_addr == A_STAT;

    mmtc_prescaler #(.PRE_W(PRE_W)) u_pre (.clk(clk), .rst(rst), .ticks(ticks));

    mmtc_srcsel #(.NTAP(NTAP)) u_src (
        .clk(clk), .rst(rst), .pin_in(pin_in), .sib_flag(sib_flag), .ticks(ticks),
        .pri_sel(mode_r.pri_sel), .sec_sel(mode_r.sec_sel),
        .p_lvl(p_lvl), .p_rise(p_rise), .p_fall(p_fall),
        .s_lvl(s_lvl), .s_rise(s_rise), .s_fall(s_fall));

    always_comb begin
        up_s = 1'b0;
        dn_s = 1'b0;
        if (run_en) begin
            case (mode_r.cmode)
                CM_RISE:   begin up_s = p_rise & ~mode_r.dir; dn_s = p_rise & mode_r.dir; end
                CM_BOTH:   begin up_s = (p_rise | p_fall) & ~mode_r.dir;
                                 dn_s = (p_rise | p_fall) & mode_r.dir; end
                CM_GATED:  begin up_s = p_rise & s_lvl & ~mode_r.dir;
                                 dn_s = p_rise & s_lvl & mode_r.dir; end
                CM_QUAD:   {up_s, dn_s} = quad_step(p_rise, p_fall, s_rise, s_fall, p_lvl, s_lvl);
                CM_SECDIR: begin up_s = p_rise & ~s_lvl; dn_s = p_rise & s_lvl; end
                CM_TRIG:   begin up_s = p_rise & trig_run & ~mode_r.dir;
                                 dn_s = p_rise & trig_run & mode_r.dir; end
                default: ;
            endcase
        end
        step     = up_s | dn_s;
        stepped  = dn_s ? cnt - 1'b1 : cnt + 1'b1;
        target   = (dn_s || (mode_r.omode == OM_ALT && alt)) ? cmpb_r : cmpa_r;
        roll     = (up_s && cnt == '1) || (dn_s && cnt == '0);
        hit      = step && !roll && stepped == target;
        nxt      = (roll || (hit && mode_r.len)) ? load_r : stepped;
        cmp_evt  = hit;
        roll_evt = step && roll;
        cap_evt  = mode_r.cap_fall ? s_fall : s_rise;
        active   = run_en && !(mode_r.cmode inside {CM_IDLE, CM_CASC})
                   && (mode_r.cmode != CM_TRIG || trig_run);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmpa_r <= '0; cmpb_r <= '0; load_r <= '0; capt_r <= '0; cnt <= '0;
            mode_r <= '0; run_en <= 1'b0; ie_r <= 1'b0; cmp_flag <= 1'b0;
            trig_run <= 1'b0; alt <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == A_CMPA) cmpa_r <= cfg_wdata;
            if (cfg_we && cfg_addr == A_CMPB) cmpb_r <= cfg_wdata;
            if (cfg_we && cfg_addr == A_LOAD) load_r <= cfg_wdata;
            if (cfg_we && cfg_addr == A_MODE) mode_r <= mode_t'(cfg_wdata[15:0]);

            if (cnt_wr)    cnt <= cfg_wdata;
            else if (step) cnt <= nxt;

            if (stat_wr) begin
                run_en <= cfg_wdata[2];
                ie_r   <= cfg_wdata[1];
            end else if (cmp_evt && mode_r.once) begin
                run_en <= 1'b0;
            end

            if (cmp_evt)                      cmp_flag <= 1'b1;
            else if (stat_wr && cfg_wdata[0]) cmp_flag <= 1'b0;

            if (mode_r.cmode != CM_TRIG)   trig_run <= 1'b0;
            else if (cmp_evt)              trig_run <= 1'b0;
            else if (s_rise && run_en)     trig_run <= 1'b1;

            if (mode_r.omode != OM_ALT) alt <= 1'b0;
            else if (cmp_evt)           alt <= ~alt;

            if (cap_evt) capt_r <= cnt;
        end
    end

    mmtc_outflag u_out (
        .clk(clk), .rst(rst), .omode(mode_r.omode), .active(active), .p_lvl(p_lvl),
        .cmp_evt(cmp_evt), .roll_evt(roll_evt), .s_rise(s_rise), .out_flag(out_flag));

    assign cmp_irq = cmp_flag & ie_r;

    always_comb begin
        case (cfg_addr)
            A_CMPA:  cfg_rdata = cmpa_r;
            A_CMPB:  cfg_rdata = cmpb_r;
            A_CAPT:  cfg_rdata = capt_r;
            A_LOAD:  cfg_rdata = load_r;
            A_COUNT: cfg_rdata = cnt;
            A_MODE:  cfg_rdata = CNT_W'(mode_r);
            A_STAT:  cfg_rdata = {{(CNT_W-3){1'b0}}, run_en, ie_r, cmp_flag};
            default: cfg_rdata = '0;
        endcase
    end

    // R13
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_wr) |=> $stable(cnt));
    // R12
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag) |-> $past(cmp_evt));
    // R9
    once_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_r.once && cmp_evt && !stat_wr) |=> !run_en);
    // R8
    len_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_r.len && cmp_evt && !cnt_wr) |=> cnt == $past(load_r));
    // R10
    capt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(capt_r));
endmodule

// File: tb/mmtc_channel_tb.sv
module mmtc_channel_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic [3:0]  pins = '0, sibs = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0, cfg_rdata;
    logic        out_flag, cmp_irq;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic [15:0] act; logic [15:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmtc_channel u_dut (
        .clk(clk), .rst(rst), .pin_in(pins), .sib_flag(sibs), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .out_flag(out_flag), .cmp_irq(cmp_irq));

    // mode word: [15] capture-on-fall, [14:12] count mode, [11:8] primary,
    // [7:6] secondary, [5] once, [4] length, [3] dir, [2:0] output mode
    function automatic logic [15:0] mk(int cm, int pri, int sec, int om,
                                       bit dir, bit len, bit once, bit capf);
        return {capf, 3'(cm), 4'(pri), 2'(sec), once, len, dir, 3'(om)};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        item_t it;
        it.act = act; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin : monitor
        item_t it;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_checks++;
            if (it.act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, it.act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic rdchk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] d;
        rd(a, d);
        chk(d, exp, tag);
    endtask

    task automatic run(input int n);
        wr(3'd6, 16'h0006);
        repeat (n - 1) @(negedge clk);
        wr(3'd6, 16'h0002);
    endtask

    task automatic pulse(input int idx, input bit sib);
        if (sib) sibs[idx] = 1'b1; else pins[idx] = 1'b1;
        @(negedge clk);
        if (sib) sibs[idx] = 1'b0; else pins[idx] = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rdchk(3'd4, 16'h0, "R1 count");
        rdchk(3'd6, 16'h0, "R1 status");
        rdchk(3'd5, 16'h0, "R1 mode");
        rdchk(3'd2, 16'h0, "R1 capture");
        chk({15'b0, out_flag}, 16'h0, "R1 out");
        chk({15'b0, cmp_irq}, 16'h0, "R1 irq");

        // R2 prescaled clock sources
        wr(3'd0, 16'hFFFF);
        wr(3'd5, mk(1, 8, 0, 0, 0, 0, 0, 0)); wr(3'd4, 0); run(20);
        rdchk(3'd4, 16'd20, "R2 div1");
        wr(3'd5, mk(1, 11, 0, 0, 0, 0, 0, 0)); wr(3'd4, 0); run(64);
        rdchk(3'd4, 16'd8, "R2 div8");
        wr(3'd5, mk(1, 15, 0, 0, 0, 0, 0, 0)); wr(3'd4, 0); run(256);
        rdchk(3'd4, 16'd2, "R2 div128");
        // R2 sibling source
        wr(3'd5, mk(1, 5, 0, 0, 0, 0, 0, 0)); wr(3'd4, 0);
        wr(3'd6, 16'h0006);
        pulse(1, 1); pulse(1, 1); pulse(0, 1);
        wr(3'd6, 16'h0002);
        rdchk(3'd4, 16'd2, "R2 sibling 1");

        // R3 both edges, then idle mode
        wr(3'd5, mk(2, 0, 0, 0, 0, 0, 0, 0)); wr(3'd4, 0);
        wr(3'd6, 16'h0006);
        pulse(0, 0); pulse(0, 0); pulse(0, 0);
        wr(3'd6, 16'h0002);
        rdchk(3'd4, 16'd6, "R3 both edges");
        wr(3'd5, mk(0, 0, 0, 0, 0, 0, 0, 0));
        wr(3'd6, 16'h0006); pulse(0, 0); pulse(0, 0); wr(3'd6, 16'h0002);
        rdchk(3'd4, 16'd6, "R3 idle mode");

        // R13 disabled hold
        wr(3'd5, mk(1, 0, 0, 0, 0, 0, 0, 0));
        pulse(0, 0); pulse(0, 0);
        rdchk(3'd4, 16'd6, "R13 hold when disabled");

        // R4 gated
        wr(3'd5, mk(3, 8, 1, 0, 0, 0, 0, 0)); wr(3'd4, 0);
        wr(3'd6, 16'h0006);
        repeat (3) @(negedge clk);
        pins[1] = 1'b1; repeat (5) @(negedge clk); pins[1] = 1'b0;
        repeat (3) @(negedge clk);
        wr(3'd6, 16'h0002);
        rdchk(3'd4, 16'd5, "R4 gated count");

        // R6 direction from secondary
        wr(3'd5, mk(5, 0, 1, 0, 0, 0, 0, 0)); wr(3'd4, 16'd100);
        pins[1] = 1'b1;
        wr(3'd6, 16'h0006); pulse(0, 0); pulse(0, 0); pulse(0, 0); wr(3'd6, 16'h0002);
        rdchk(3'd4, 16'd97, "R6 down while high");
        pins[1] = 1'b0;
        wr(3'd6, 16'h0006); pulse(0, 0); pulse(0, 0); wr(3'd6, 16'h0002);
        rdchk(3'd4, 16'd99, "R6 up while low");

        // R5 quadrature
        wr(3'd5, mk(4, 0, 1, 0, 0, 0, 0, 0)); wr(3'd4, 16'd50);
        wr(3'd6, 16'h0006);
        pins[0] = 1; @(negedge clk); pins[1] = 1; @(negedge clk);
        pins[0] = 0; @(negedge clk); pins[1] = 0; @(negedge clk);
        rdchk(3'd4, 16'd54, "R5 A leads");
        pins[1] = 1; @(negedge clk); pins[0] = 1; @(negedge clk);
        pins[1] = 0; @(negedge clk); pins[0] = 0; @(negedge clk);
        rdchk(3'd4, 16'd50, "R5 B leads");
        wr(3'd6, 16'h0002);

        // R7 triggered count
        wr(3'd5, mk(6, 8, 1, 0, 0, 0, 0, 0)); wr(3'd0, 16'd6); wr(3'd4, 0);
        wr(3'd6, 16'h0006);
        repeat (5) @(negedge clk);
        rdchk(3'd4, 16'd0, "R7 waits for trigger");
        pins[1] = 1; repeat (15) @(negedge clk); pins[1] = 0;
        rdchk(3'd4, 16'd6, "R7 stops at compare");
        wr(3'd6, 16'h0002);

        // R8 reload at compare, R12 flag
        wr(3'd6, 16'h0003);
        wr(3'd5, mk(1, 8, 0, 0, 0, 1, 0, 0)); wr(3'd3, 16'd2); wr(3'd0, 16'd5); wr(3'd4, 16'd2);
        run(7);
        rdchk(3'd4, 16'd3, "R8 reload at compare");
        chk({15'b0, cmp_irq}, 16'h1, "R12 irq raised");
        rdchk(3'd6, 16'h0003, "R12 status flag");
        wr(3'd6, 16'h0002);
        chk({15'b0, cmp_irq}, 16'h1, "R12 write 0 keeps flag");
        wr(3'd6, 16'h0003);
        chk({15'b0, cmp_irq}, 16'h0, "R12 w1c clears irq");
        rdchk(3'd6, 16'h0002, "R12 status after clear");

        // R8 rollover, R11 set on compare / clear on rollover
        wr(3'd5, mk(1, 8, 0, 6, 0, 0, 0, 0)); wr(3'd0, 16'hFFFF); wr(3'd3, 16'h0010);
        wr(3'd4, 16'hFFFE);
        run(1);
        rdchk(3'd4, 16'hFFFF, "R8 at max");
        chk({15'b0, out_flag}, 16'h1, "R11 set on compare");
        run(1);
        rdchk(3'd4, 16'h0010, "R8 rollover loads");
        chk({15'b0, out_flag}, 16'h0, "R11 clear on rollover");

        // R9 one-shot down and up
        wr(3'd5, mk(1, 8, 0, 0, 1, 0, 1, 0)); wr(3'd1, 16'd7); wr(3'd4, 16'd10);
        wr(3'd6, 16'h0006); repeat (10) @(negedge clk);
        rdchk(3'd4, 16'd7, "R9 down stops at compare B");
        rdchk(3'd6, 16'h0003, "R9 enable cleared");
        wr(3'd6, 16'h0003);
        wr(3'd5, mk(1, 8, 0, 0, 0, 0, 1, 0)); wr(3'd0, 16'd4); wr(3'd4, 0);
        wr(3'd6, 16'h0006); repeat (10) @(negedge clk);
        rdchk(3'd4, 16'd4, "R9 up stops at compare A");
        wr(3'd6, 16'h0003);

        // R10 capture edges
        wr(3'd5, mk(0, 0, 2, 0, 0, 0, 0, 0)); wr(3'd4, 16'h1234);
        pins[2] = 1; @(negedge clk);
        rdchk(3'd2, 16'h1234, "R10 rising capture");
        wr(3'd4, 16'h0055); pins[2] = 0; @(negedge clk);
        rdchk(3'd2, 16'h1234, "R10 falling ignored");
        wr(3'd5, mk(0, 0, 2, 0, 0, 0, 0, 1)); wr(3'd4, 16'h0077);
        pins[2] = 1; @(negedge clk);
        rdchk(3'd2, 16'h1234, "R10 rising ignored");
        pins[2] = 0; @(negedge clk);
        rdchk(3'd2, 16'h0077, "R10 falling capture");

        // R11 toggle
        wr(3'd5, mk(1, 8, 0, 3, 0, 1, 0, 0)); wr(3'd3, 0); wr(3'd0, 16'd3); wr(3'd4, 0);
        run(3);
        chk({15'b0, out_flag}, 16'h1, "R11 toggle high");
        run(3);
        chk({15'b0, out_flag}, 16'h0, "R11 toggle low");
        // R11 alternating targets
        wr(3'd5, mk(1, 8, 0, 4, 0, 0, 0, 0)); wr(3'd1, 16'd6); wr(3'd4, 0);
        run(3);
        rdchk(3'd4, 16'd3, "R11 alt first target");
        chk({15'b0, out_flag}, 16'h1, "R11 alt toggle A");
        run(3);
        rdchk(3'd4, 16'd6, "R11 alt second target");
        chk({15'b0, out_flag}, 16'h0, "R11 alt toggle B");
        // R11 set on compare, clear on secondary edge
        wr(3'd5, mk(1, 8, 1, 5, 0, 0, 0, 0)); wr(3'd0, 16'd2); wr(3'd4, 0);
        run(2);
        chk({15'b0, out_flag}, 16'h1, "R11 set before secondary");
        pulse(1, 0);
        chk({15'b0, out_flag}, 16'h0, "R11 cleared by secondary");
        // R11 set then clear on compare
        wr(3'd5, mk(1, 8, 0, 2, 0, 0, 0, 0)); wr(3'd4, 0); run(2);
        chk({15'b0, out_flag}, 16'h1, "R11 set mode");
        wr(3'd5, mk(1, 8, 0, 1, 0, 0, 0, 0)); wr(3'd4, 0); run(2);
        chk({15'b0, out_flag}, 16'h0, "R11 clear mode");
        // R11 active while counting
        wr(3'd5, mk(1, 8, 0, 0, 0, 0, 0, 0));
        wr(3'd6, 16'h0006); #1;
        chk({15'b0, out_flag}, 16'h1, "R11 active when enabled");
        wr(3'd6, 16'h0002); #1;
        chk({15'b0, out_flag}, 16'h0, "R11 inactive when disabled");
        // R11 gated primary level
        wr(3'd5, mk(1, 0, 0, 7, 0, 0, 0, 0));
        wr(3'd6, 16'h0006);
        pins[0] = 1; #1;
        chk({15'b0, out_flag}, 16'h1, "R11 gated high");
        @(negedge clk); pins[0] = 0; #1;
        chk({15'b0, out_flag}, 16'h0, "R11 gated low");
        @(negedge clk);
        wr(3'd6, 16'h0002);

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule